// File: doc/BRIEF.md
# Prefixed Bit-Manipulation ALU Unit

This unit executes the second byte of a two-byte prefixed instruction class on one 8-bit operand. It performs eight shift and rotate kinds, a nibble swap among them, plus bit test, bit clear and bit set on any of the eight bit positions. The core that uses it fetches the prefix and the second byte, reads the operand from the slot the unit names (a register or the memory byte addressed by the HL pair), and pulses `start_i`. One cycle later the unit presents the result byte, the new flags, a write-back enable and the slot to write.

The control is a two-state machine. `ST_IDLE` waits with `done_o` low and every result output held. A `start_i` pulse moves it to `ST_RESULT` (transition GO), where `done_o` is high for that cycle. From `ST_RESULT` a new `start_i` keeps it in `ST_RESULT` with fresh results (transition AGAIN), and otherwise it returns to `ST_IDLE` (transition RETIRE). Reset forces `ST_IDLE` and clears every output.

Flags travel as a 4-bit vector: bit 3 is zero, bit 2 is subtract, bit 1 is half-carry, bit 0 is carry.

Top module: `cbx_unit`

## Requirements
- R1: After reset all outputs are 0. A `start_i` sampled on a clock edge makes `done_o` high, with valid results, for exactly the following cycle; without `start_i`, `done_o` is low the next cycle.
- R2: Opcode bits 2:0 name the operand slot (0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at HL, 7=A); `slot_o` reports that field and `mem_slot_o` is high exactly when it equals 6.
- R3: Opcodes 0x00-0x07 rotate left within the byte and 0x08-0x0F rotate right within the byte; the bit moved across the end goes to carry.
- R4: Opcodes 0x10-0x17 rotate left through carry and 0x18-0x1F rotate right through carry: the old carry enters the vacated bit and the bit leaving goes to carry.
- R5: Opcodes 0x20-0x27 shift left with 0 entering bit 0; 0x28-0x2F shift right keeping bit 7; 0x38-0x3F shift right with 0 entering bit 7; the bit leaving goes to carry.
- R6: Opcodes 0x30-0x37 exchange the two nibbles and clear carry.
- R7: For every opcode 0x00-0x3F the zero flag is set exactly when the result is 0, subtract and half-carry are cleared, and write-back is enabled.
- R8: Opcodes 0x40-0x7F test bit n (n = opcode bits 5:3): zero is set when that bit is 0, subtract is cleared, half-carry is set, carry keeps its input value, write-back is disabled and `res_o` echoes the operand.
- R9: Opcodes 0x80-0xBF clear bit n (opcode bits 5:3) of the operand, enable write-back and pass the input flags through unchanged.
- R10: Opcodes 0xC0-0xFF set bit n (opcode bits 5:3) of the operand, enable write-back and pass the input flags through unchanged.
- R11: A cycle without `start_i` leaves `res_o`, `flg_o`, `wr_en_o`, `slot_o` and `mem_slot_o` at their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Execute the presented opcode this cycle |
| op_i | input | 8 | Second opcode byte |
| val_i | input | 8 | Operand value read from the named slot |
| flg_i | input | 4 | Current flags {Z, N, H, C} |
| done_o | output | 1 | Result valid this cycle |
| res_o | output | 8 | Result byte |
| flg_o | output | 4 | New flags {Z, N, H, C} |
| wr_en_o | output | 1 | Result must be written back to the slot |
| slot_o | output | 3 | Operand slot index |
| mem_slot_o | output | 1 | Slot is the memory byte at HL |

## Verification
The in-RTL assertions watch on every cycle the handshake timing, the hold of outputs while idle, the flag rules of each opcode group (zero from result in the shift group, fixed subtract and half-carry, carry kept by bit test, flags passed through by clear and set), the write-back enable and the memory-slot flag. The exact data movement of each shift and rotate kind, the carry chained through the rotates, and correct bit indexing for all eight positions are shown only by the bench, which sweeps every opcode against a behavioural model over edge operands and random traffic, including back-to-back starts.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
    localparam int DW    = 8;
    localparam int FW    = 4;
    localparam int IDX_W = $clog2(DW);
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] MEM_SLOT = 3'd6;

    // flag vector positions
    localparam int F_Z = 3;
    localparam int F_N = 2;
    localparam int F_H = 1;
    localparam int F_C = 0;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    // order matches opcode bits 5:3 in the shift group
    typedef enum logic [2:0] {
        SK_ROTL  = 3'd0,
        SK_ROTR  = 3'd1,
        SK_ROTLC = 3'd2,
        SK_ROTRC = 3'd3,
        SK_ASHL  = 3'd4,
        SK_ASHR  = 3'd5,
        SK_NSWAP = 3'd6,
        SK_LSHR  = 3'd7
    } shk_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } st_e;

    typedef struct packed {
        grp_e              grp;
        shk_e              shk;
        logic [IDX_W-1:0]  idx;
        logic [SEL_W-1:0]  slot;
        logic              mem;
    } dec_t;
endpackage

// File: rtl/cbx_decode.sv
module cbx_decode
    import cbx_pkg::*;
(
    input  logic [DW-1:0] op,
    output dec_t          dec
);
    always_comb begin
        dec.grp  = grp_e'(op[7:6]);
        dec.shk  = shk_e'(op[5:3]);
        dec.idx  = op[5:3];
        dec.slot = op[2:0];
        dec.mem  = (op[2:0] == MEM_SLOT);
    end
endmodule

// File: rtl/cbx_shift.sv
module cbx_shift
    import cbx_pkg::*;
(
    input  shk_e          kind,
    input  logic [DW-1:0] din,
    input  logic          cin,
    output logic [DW-1:0] dout,
    output logic          cout
);
    localparam int HALF = DW / 2;

    always_comb begin
        unique case (kind)
            SK_ROTL: begin
                dout = {din[DW-2:0], din[DW-1]};
                cout = din[DW-1];
            end
            SK_ROTR: begin
                dout = {din[0], din[DW-1:1]};
                cout = din[0];
            end
            SK_ROTLC: begin
                dout = {din[DW-2:0], cin};
                cout = din[DW-1];
            end
            SK_ROTRC: begin
                dout = {cin, din[DW-1:1]};
                cout = din[0];
            end
            SK_ASHL: begin
                dout = {din[DW-2:0], 1'b0};
                cout = din[DW-1];
            end
            SK_ASHR: begin
                dout = {din[DW-1], din[DW-1:1]};
                cout = din[0];
            end
            SK_NSWAP: begin
                dout = {din[HALF-1:0], din[DW-1:HALF]};
                cout = 1'b0;
            end
            SK_LSHR: begin
                dout = {1'b0, din[DW-1:1]};
                cout = din[0];
            end
        endcase
    end
endmodule

// File: rtl/cbx_bitop.sv
module cbx_bitop
    import cbx_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    cleared,
    output logic [DW-1:0]    setted,
    output logic             picked
);
    logic [DW-1:0] mask;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (idx == IDX_W'(i));
    end

    assign cleared = din & ~mask;
    assign setted  = din | mask;
    assign picked  = |(din & mask);
endmodule

// File: rtl/cbx_unit.sv
module cbx_unit
    import cbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [7:0]    op_i,
    input  logic [7:0]    val_i,
    input  logic [3:0]    flg_i,
    output logic          done_o,
    output logic [7:0]    res_o,
    output logic [3:0]    flg_o,
    output logic          wr_en_o,
    output logic [2:0]    slot_o,
    output logic          mem_slot_o
);
    st_e           state_q, state_d;
    dec_t          dec;
    logic [DW-1:0] sh_res, clr_res, set_res;
    logic          sh_c, bit_val;
    logic [DW-1:0] nxt_res;
    logic [FW-1:0] nxt_flg;
    logic          nxt_wr;

    cbx_decode u_dec (
        .op  (op_i),
        .dec (dec)
    );

    cbx_shift u_shift (
        .kind (dec.shk),
        .din  (val_i),
        .cin  (flg_i[F_C]),
        .dout (sh_res),
        .cout (sh_c)
    );

    cbx_bitop u_bit (
        .idx     (dec.idx),
        .din     (val_i),
        .cleared (clr_res),
        .setted  (set_res),
        .picked  (bit_val)
    );

    always_comb begin
        nxt_res = val_i;
        nxt_flg = flg_i;
        nxt_wr  = 1'b1;
        unique case (dec.grp)
            GRP_SHIFT: begin
                nxt_res = sh_res;
                nxt_flg = {(sh_res == '0), 1'b0, 1'b0, sh_c};
            end
            GRP_TEST: begin
                nxt_wr  = 1'b0;
                nxt_flg = {~bit_val, 1'b0, 1'b1, flg_i[F_C]};
            end
            GRP_CLR: nxt_res = clr_res;
            GRP_SET: nxt_res = set_res;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_RESULT;
            ST_RESULT: state_d = start_i ? ST_RESULT : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o      <= '0;
            flg_o      <= '0;
            wr_en_o    <= 1'b0;
            slot_o     <= '0;
            mem_slot_o <= 1'b0;
        end else if (start_i) begin
            res_o      <= nxt_res;
            flg_o      <= nxt_flg;
            wr_en_o    <= nxt_wr;
            slot_o     <= dec.slot;
            mem_slot_o <= dec.mem;
        end
    end

    assign done_o = (state_q == ST_RESULT);

    AST_START_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o) else $error("start not answered"); // R1
    AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o) else $error("spurious done"); // R1
    AST_MEM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (mem_slot_o == (slot_o == 3'd6))) else $error("mem slot flag"); // R2
    AST_SHIFT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[7:6] == 2'b00) |=>
            (flg_o[F_Z] == (res_o == 8'h00)) && !flg_o[F_N] && !flg_o[F_H] && wr_en_o)
        else $error("shift flags"); // R7
    AST_TEST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[7:6] == 2'b01) |=>
            !wr_en_o && !flg_o[F_N] && flg_o[F_H] && (flg_o[F_C] == $past(flg_i[F_C])))
        else $error("test flags"); // R8
    AST_CLRSET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[7]) |=> (flg_o == $past(flg_i)) && wr_en_o)
        else $error("clear/set flags"); // R9
    AST_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[7:6] == 2'b11) |=> res_o[$past(op_i[5:3])])
        else $error("set bit low"); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(res_o) && $stable(flg_o) && $stable(wr_en_o) && $stable(slot_o))
        else $error("outputs moved while idle"); // R11
endmodule

// File: tb/cbx_unit_bench.sv
module cbx_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] op_i = '0;
    logic [7:0] val_i = '0;
    logic [3:0] flg_i = '0;
    logic       done_o;
    logic [7:0] res_o;
    logic [3:0] flg_o;
    logic       wr_en_o;
    logic [2:0] slot_o;
    logic       mem_slot_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // expectation state, updated once per clock
    bit         e_done = 0;
    int         e_res = 0, e_flg = 0, e_wr = 0, e_slot = 0, e_mem = 0;
    string      e_tag = "R1";
    string      e_ftag = "R1";

    always #2 clk = ~clk;

    cbx_unit u_cbx_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .val_i(val_i), .flg_i(flg_i), .done_o(done_o), .res_o(res_o),
        .flg_o(flg_o), .wr_en_o(wr_en_o), .slot_o(slot_o), .mem_slot_o(mem_slot_o)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model: returns result, flags, write enable and tags
    task automatic model(input int op, input int v, input int f,
                         output int r, output int fl, output int wr,
                         output string rtag, output string ftag);
        int grp, k, c, co, b;
        grp = op / 64;
        k   = (op / 8) % 8;
        c   = f % 2;
        co  = 0;
        r   = v;
        fl  = f;
        wr  = 1;
        rtag = "R9";
        ftag = "R9";
        if (grp == 0) begin
            case (k)
                0: begin r = (v * 2 + v / 128) % 256; co = v / 128; rtag = "R3"; end
                1: begin r = v / 2 + (v % 2) * 128;   co = v % 2;   rtag = "R3"; end
                2: begin r = (v * 2 + c) % 256;       co = v / 128; rtag = "R4"; end
                3: begin r = v / 2 + c * 128;         co = v % 2;   rtag = "R4"; end
                4: begin r = (v * 2) % 256;           co = v / 128; rtag = "R5"; end
                5: begin r = v / 2 + (v / 128) * 128; co = v % 2;   rtag = "R5"; end
                6: begin r = (v % 16) * 16 + v / 16;  co = 0;       rtag = "R6"; end
                default: begin r = v / 2;             co = v % 2;   rtag = "R5"; end
            endcase
            fl = (r == 0 ? 8 : 0) + co;
            ftag = (k == 6) ? "R6" : "R7";
        end else if (grp == 1) begin
            b  = (v >> k) % 2;
            fl = (b == 0 ? 8 : 0) + 2 + c;
            wr = 0;
            rtag = "R8";
            ftag = "R8";
        end else if (grp == 2) begin
            r = v & ~(1 << k) & 255;
        end else begin
            r = v | (1 << k);
            rtag = "R10";
            ftag = "R10";
        end
    endtask

    // one clock: compare previous expectation, then drive and predict
    task automatic step(bit go, int op, int v, int f);
        int r, fl, wr;
        string rt, ft;
        @(negedge clk);
        check(done_o == e_done, "R1 done", done_o, e_done);
        check(res_o == e_res[7:0], e_done ? e_tag : "R11 res", res_o, e_res);
        check(flg_o == e_flg[3:0], e_done ? e_ftag : "R11 flg", flg_o, e_flg);
        check(wr_en_o == e_wr[0], e_done ? e_ftag : "R11 wr", wr_en_o, e_wr);
        check(slot_o == e_slot[2:0], "R2 slot", slot_o, e_slot);
        check(mem_slot_o == e_mem[0], "R2 mem", mem_slot_o, e_mem);
        start_i = go;
        op_i    = op[7:0];
        val_i   = v[7:0];
        flg_i   = f[3:0];
        e_done  = go;
        if (go) begin
            model(op, v, f, r, fl, wr, rt, ft);
            e_res = r; e_flg = fl; e_wr = wr;
            e_slot = op % 8; e_mem = (op % 8 == 6) ? 1 : 0;
            e_tag = rt; e_ftag = ft;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R1)
        check(done_o == 1'b0 && res_o == 8'h00 && flg_o == 4'h0 && !wr_en_o &&
              slot_o == 3'd0 && !mem_slot_o, "R1 reset", {done_o, res_o}, 0);
        rst_n = 1'b1;
        // directed corners
        step(1, 8'h07, 8'h80, 4'h0);   // R3 rotate left carry out
        step(1, 8'h0E, 8'h01, 4'h0);   // R3 rotate right, memory slot R2
        step(1, 8'h10, 8'h80, 4'h0);   // R4 through carry, result zero
        step(1, 8'h18, 8'h00, 4'h1);   // R4 carry enters bit 7
        step(1, 8'h28, 8'h81, 4'h0);   // R5 arithmetic right
        step(1, 8'h3B, 8'h01, 4'h0);   // R5 logical right to zero
        step(1, 8'h20, 8'hFF, 4'h0);   // R5 shift left
        step(1, 8'h36, 8'hA5, 4'h1);   // R6 swap clears carry
        step(1, 8'h7F, 8'h7F, 4'h1);   // R8 bit 7 clear
        step(1, 8'h40, 8'h01, 4'h0);   // R8 bit 0 set
        step(0, 8'hFF, 8'h00, 4'hF);   // R11 ignored inputs
        step(0, 8'h00, 8'h55, 4'h0);   // R11
        step(1, 8'hBE, 8'hFF, 4'hB);   // R9 clear bit 7
        step(1, 8'hC1, 8'h00, 4'h5);   // R10 set bit 0
        // sweep every opcode
        for (int op = 0; op < 256; op++) begin
            step(1, op, 8'h5A, op % 16);
            step(op % 3 == 0 ? 0 : 1, op, 8'hC3, (op * 7) % 16);
        end
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 4) != 0, $urandom % 256, $urandom % 256, $urandom % 16);
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=0x0 expected=0x1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule